// File: doc/BRIEF.md
# Decimal-Word Accumulator Processor Core

This block is a small processor with a single accumulator. Every instruction and every data word is three decimal digits, each held as a 4-bit BCD digit. The top digit of an instruction picks the operation and the lower two digits give an address from 00 to 99. The core repeats a fetch, decode and execute cycle against an external synchronous memory of 100 words, using a request and ready handshake. Its architectural state is an accumulator, a program counter, an instruction register, a one-bit equality flag and an arithmetic carry/borrow flag.

Arithmetic works on unsigned decimal values from 000 to 999 and wraps modulo 1000. A compare only records whether the accumulator equals the memory operand. The equality flag steers a conditional branch. A halt instruction parks the core until the next reset. The memory is not part of the block: the surrounding system, or a test model, answers each request after any number of wait cycles.

Top module: `dacc_core`

## Requirements
- R1: While reset is asserted and on release, the accumulator, program counter (`pc`), equality flag (`cc`), carry flag and `halted` all read zero.
- R2: Each fetch reads the word at `pc`, and `pc` then advances by one in BCD, going from 99 back to 00, unless a branch replaces it.
- R3: An instruction word carries the opcode in bits [11:8] and a two-digit BCD address in bits [7:0] (tens in [7:4]). The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 compare, 6 branch and 7 branch-if-equal.
- R4: Load copies the memory word at the address into the accumulator. Store writes the accumulator to that address with `mem_we` high.
- R5: Add sets the accumulator to (acc + operand) mod 1000 and sets `carry` to 1 exactly when the true sum exceeds 999.
- R6: Subtract sets the accumulator to (acc - operand) mod 1000 and sets `carry` to 1 exactly when the operand exceeds the accumulator (a borrow).
- R7: Compare sets `cc` to 1 when the accumulator equals the operand and to 0 otherwise, and leaves the accumulator unchanged. Only a completed memory read can change `acc`, `cc` or `carry`.
- R8: Branch loads the address field into `pc`. Branch-if-equal does so only when `cc` is 1, and otherwise continues with the next sequential word.
- R9: After a halt, `halted` stays 1 and `mem_req` stays 0 until reset.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. A transfer completes in the cycle in which `mem_ready` is high.
- R11: Opcodes 8 and 9 do nothing: the accumulator and both flags keep their values and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 8 | BCD word address |
| mem_wdata | output | 12 | BCD write data (accumulator) |
| mem_rdata | input | 12 | BCD read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Completes the pending transfer |
| acc | output | 12 | Accumulator |
| pc | output | 8 | Program counter, BCD |
| cc | output | 1 | Equality flag |
| carry | output | 1 | Carry from add or borrow from subtract |
| halted | output | 1 | Core has stopped on a halt |

## Verification
The add and subtract paths are swept over a grid of operand pairs. The grid includes 000, 999, digit-rollover values such as 009, 099 and 499, and equal pairs. This separates ripple errors between digits, a missed decimal adjust, and a swapped carry or borrow sense. The memory latency changes from run to run, so transfers are checked both with wait cycles and without them.

A directed program chains compares, taken and untaken conditional branches, the two no-op digits and a stalled store. Only a correct path reaches the final program counter and leaves the expected memory contents. A second program runs execution through address 99 so that the fetch address must wrap to 00.

// File: rtl/dacc_pkg.sv
`timescale 1ns/1ps
package dacc_pkg;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_READ   = 3'd3,
      ST_WRITE  = 3'd4,
      ST_HALT   = 3'd5
   } dacc_state_e;

   localparam logic [3:0] OPC_HALT  = 4'd0;
   localparam logic [3:0] OPC_LOAD  = 4'd1;
   localparam logic [3:0] OPC_STORE = 4'd2;
   localparam logic [3:0] OPC_ADD   = 4'd3;
   localparam logic [3:0] OPC_SUB   = 4'd4;
   localparam logic [3:0] OPC_CMP   = 4'd5;
   localparam logic [3:0] OPC_JMP   = 4'd6;
   localparam logic [3:0] OPC_JEQ   = 4'd7;

endpackage

// File: rtl/dacc_bcd_addsub.sv
`timescale 1ns/1ps
module dacc_bcd_addsub #(
   parameter int DIGITS = 3
) (
   input  logic [4*DIGITS-1:0] a,
   input  logic [4*DIGITS-1:0] b,
   input  logic                sub,
   output logic [4*DIGITS-1:0] y,
   output logic                flag
);

   logic [DIGITS:0] chain;
   assign chain[0] = sub;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_digit
         logic [3:0] b_eff;
         logic [4:0] raw;
         logic [4:0] adj;
         always_comb begin
            b_eff = sub ? (4'd9 - b[4*g +: 4]) : b[4*g +: 4];
            raw   = {1'b0, a[4*g +: 4]} + {1'b0, b_eff} + {4'd0, chain[g]};
            adj   = raw - 5'd10;
         end
         assign chain[g+1]  = (raw > 5'd9);
         assign y[4*g +: 4] = (raw > 5'd9) ? adj[3:0] : raw[3:0];
      end
   endgenerate

   // subtract is add of nines' complement plus one: carry-out means no borrow
   assign flag = sub ? ~chain[DIGITS] : chain[DIGITS];

endmodule

// File: rtl/dacc_bcd_inc.sv
`timescale 1ns/1ps
module dacc_bcd_inc #(
   parameter int DIGITS = 2
) (
   input  logic [4*DIGITS-1:0] a,
   output logic [4*DIGITS-1:0] y
);

   logic [DIGITS:0] chain;
   assign chain[0] = 1'b1;

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_digit
         logic at_nine;
         assign at_nine     = (a[4*g +: 4] == 4'd9);
         assign chain[g+1]  = chain[g] & at_nine;
         assign y[4*g +: 4] = (chain[g] & at_nine) ? 4'd0 : (a[4*g +: 4] + {3'd0, chain[g]});
      end
   endgenerate

endmodule

// File: rtl/dacc_ctrl.sv
`timescale 1ns/1ps
module dacc_ctrl
   import dacc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [3:0]  opcode,
   input  logic        eq_flag,
   input  logic        mem_ready,
   output dacc_state_e state,
   output logic        fetch_done,
   output logic        ir_load,
   output logic        read_done,
   output logic        pc_jump
);

   dacc_state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_FETCH;
      else        state <= nxt;
   end

   always_comb begin
      nxt        = state;
      fetch_done = 1'b0;
      ir_load    = 1'b0;
      read_done  = 1'b0;
      pc_jump    = 1'b0;
      case (state)
         ST_FETCH: begin
            if (mem_ready) begin
               fetch_done = 1'b1;
               nxt        = ST_DECODE;
            end
         end
         ST_DECODE: begin
            ir_load = 1'b1;
            nxt     = ST_EXEC;
         end
         ST_EXEC: begin
            case (opcode)
               OPC_HALT:  nxt = ST_HALT;
               OPC_LOAD,
               OPC_ADD,
               OPC_SUB,
               OPC_CMP:   nxt = ST_READ;
               OPC_STORE: nxt = ST_WRITE;
               OPC_JMP: begin
                  pc_jump = 1'b1;
                  nxt     = ST_FETCH;
               end
               OPC_JEQ: begin
                  pc_jump = eq_flag;
                  nxt     = ST_FETCH;
               end
               default:   nxt = ST_FETCH;
            endcase
         end
         ST_READ: begin
            if (mem_ready) begin
               read_done = 1'b1;
               nxt       = ST_FETCH;
            end
         end
         ST_WRITE: begin
            if (mem_ready) nxt = ST_FETCH;
         end
         ST_HALT: nxt = ST_HALT;
         default: nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/dacc_core.sv
`timescale 1ns/1ps
module dacc_core
   import dacc_pkg::*;
#(
   parameter int DIGITS      = 3,
   parameter int ADDR_DIGITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [4*ADDR_DIGITS-1:0] mem_addr,
   output logic [4*DIGITS-1:0]      mem_wdata,
   input  logic [4*DIGITS-1:0]      mem_rdata,
   input  logic                     mem_ready,
   output logic [4*DIGITS-1:0]      acc,
   output logic [4*ADDR_DIGITS-1:0] pc,
   output logic                     cc,
   output logic                     carry,
   output logic                     halted
);

   localparam int WORD_W = 4 * DIGITS;
   localparam int ADDR_W = 4 * ADDR_DIGITS;
   localparam int OP_W   = WORD_W - ADDR_W;

   generate
      if (ADDR_DIGITS < 1) begin : g_bad_addr
         $error("dacc_core: ADDR_DIGITS must be at least 1");
      end
      if (OP_W != 4) begin : g_bad_split
         $error("dacc_core: word must be exactly one opcode digit plus the address digits");
      end
   endgenerate

   dacc_state_e         state;
   logic                fetch_done, ir_load, read_done, pc_jump;
   logic [WORD_W-1:0]   acc_q, ir_q, mdr_q, alu_y;
   logic [ADDR_W-1:0]   pc_q, pc_next;
   logic                cc_q, carry_q, alu_flag;
   logic [3:0]          opcode;
   logic [ADDR_W-1:0]   opnd_addr;

   assign opcode    = ir_q[WORD_W-1 -: 4];
   assign opnd_addr = ir_q[ADDR_W-1:0];

   dacc_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .opcode     (opcode),
      .eq_flag    (cc_q),
      .mem_ready  (mem_ready),
      .state      (state),
      .fetch_done (fetch_done),
      .ir_load    (ir_load),
      .read_done  (read_done),
      .pc_jump    (pc_jump)
   );

   dacc_bcd_addsub #(.DIGITS(DIGITS)) u_alu (
      .a    (acc_q),
      .b    (mem_rdata),
      .sub  (opcode == OPC_SUB),
      .y    (alu_y),
      .flag (alu_flag)
   );

   dacc_bcd_inc #(.DIGITS(ADDR_DIGITS)) u_pc_inc (
      .a (pc_q),
      .y (pc_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         pc_q    <= '0;
         ir_q    <= '0;
         mdr_q   <= '0;
         cc_q    <= 1'b0;
         carry_q <= 1'b0;
      end else begin
         if (fetch_done) begin
            mdr_q <= mem_rdata;
            pc_q  <= pc_next;
         end
         if (ir_load) ir_q <= mdr_q;
         if (pc_jump) pc_q <= opnd_addr;
         if (read_done) begin
            case (opcode)
               OPC_LOAD: acc_q <= mem_rdata;
               OPC_ADD,
               OPC_SUB: begin
                  acc_q   <= alu_y;
                  carry_q <= alu_flag;
               end
               OPC_CMP:  cc_q <= (mem_rdata == acc_q);
               default:  ;
            endcase
         end
      end
   end

   assign mem_req   = (state == ST_FETCH) || (state == ST_READ) || (state == ST_WRITE);
   assign mem_we    = (state == ST_WRITE);
   assign mem_addr  = (state == ST_FETCH) ? pc_q : opnd_addr;
   assign mem_wdata = acc_q;
   assign acc       = acc_q;
   assign pc        = pc_q;
   assign cc        = cc_q;
   assign carry     = carry_q;
   assign halted    = (state == ST_HALT);

endmodule

// File: rtl/dacc_core_chk.sv
`timescale 1ns/1ps
module dacc_core_chk #(
   parameter int WORD_W = 12,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [WORD_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic [WORD_W-1:0] acc,
   input logic [ADDR_W-1:0] pc,
   input logic              cc,
   input logic              carry,
   input logic              halted
);

   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (acc == '0 && pc == '0 && !cc && !carry && !halted));

   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !mem_req);

   a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);

   a_r7_acc_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(acc) |-> $past(mem_ready && !mem_we));

   a_r7_cc_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cc) |-> $past(mem_ready && !mem_we));

   a_r5_carry_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(carry) |-> $past(mem_ready && !mem_we));

endmodule

bind dacc_core dacc_core_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ready (mem_ready),
   .acc       (acc),
   .pc        (pc),
   .cc        (cc),
   .carry     (carry),
   .halted    (halted)
);

// File: tb/dacc_core_tb.sv
`timescale 1ns/1ps
module dacc_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mem_req, mem_we, mem_ready = 1'b0;
   logic [7:0]  mem_addr;
   logic [11:0] mem_wdata, mem_rdata = '0;
   logic [11:0] acc;
   logic [7:0]  pc;
   logic        cc, carry, halted;

   logic [11:0] mem [0:99];
   int lat = 0, cnt = 0, quiet_bad = 0;
   int tests = 0, fails = 0;

   always #2.5 clk = ~clk;

   dacc_core u_dut (
      .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ready(mem_ready), .acc(acc), .pc(pc), .cc(cc), .carry(carry),
      .halted(halted)
   );

   function automatic logic [11:0] bcd3(input int v);
      return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
   endfunction

   function automatic int val3(input logic [11:0] w);
      return int'(w[11:8]) * 100 + int'(w[7:4]) * 10 + int'(w[3:0]);
   endfunction

   function automatic logic [11:0] instr(input int op, input int ad);
      return {4'(op), 4'(ad / 10), 4'(ad % 10)};
   endfunction

   // memory model: answers after lat idle cycles, ready lasts one cycle
   always @(negedge clk) begin
      if (halted && mem_req) quiet_bad++;
      if (!rst_n) begin
         mem_ready = 1'b0;
         cnt = 0;
      end else if (mem_ready) begin
         mem_ready = 1'b0;
         cnt = 0;
      end else if (mem_req) begin
         if (cnt >= lat) begin
            mem_rdata = mem[int'(mem_addr[7:4]) * 10 + int'(mem_addr[3:0])];
            if (mem_we) mem[int'(mem_addr[7:4]) * 10 + int'(mem_addr[3:0])] = mem_wdata;
            mem_ready = 1'b1;
         end else begin
            cnt++;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int k = 0; k < 100; k++) mem[k] = '0;
   endtask

   task automatic run_prog(input int latency, input bit chk_rst);
      rst_n = 1'b0;
      lat = latency;
      repeat (2) @(negedge clk);
      if (chk_rst) begin
         check("R1 acc in reset", int'(acc), 0);
         check("R1 pc in reset", int'(pc), 0);
         check("R1 cc in reset", int'(cc), 0);
         check("R1 carry in reset", int'(carry), 0);
         check("R9 halted cleared by reset", int'(halted), 0);
      end
      rst_n = 1'b1;
      for (int n = 0; n < 3000 && !halted; n++) @(negedge clk);
      check("R9 program reached halt", int'(halted), 1);
   endtask

   int vals [12];

   initial begin
      vals[0] = 0;   vals[1] = 1;   vals[2] = 9;    vals[3] = 10;
      vals[4] = 99;  vals[5] = 100; vals[6] = 499;  vals[7] = 500;
      vals[8] = 501; vals[9] = 358; vals[10] = 998; vals[11] = 999;

      // R5 / R6 sweep over operand grid, both operations, varying latency
      for (int i = 0; i < 12; i++) begin
         for (int j = 0; j < 12; j++) begin
            for (int op = 3; op <= 4; op++) begin
               int ea, ec;
               clear_mem();
               mem[0]  = instr(1, 40);
               mem[1]  = instr(op, 41);
               mem[2]  = instr(0, 0);
               mem[40] = bcd3(vals[i]);
               mem[41] = bcd3(vals[j]);
               run_prog((i + j + op) % 3, (i == 0 && j == 0 && op == 3));
               if (op == 3) begin
                  ea = (vals[i] + vals[j]) % 1000;
                  ec = (vals[i] + vals[j] > 999) ? 1 : 0;
                  check("R5 add result", val3(acc), ea);
                  check("R5 add carry", int'(carry), ec);
               end else begin
                  ea = (vals[i] - vals[j] + 1000) % 1000;
                  ec = (vals[j] > vals[i]) ? 1 : 0;
                  check("R6 sub result", val3(acc), ea);
                  check("R6 sub borrow", int'(carry), ec);
               end
            end
         end
      end

      // directed program: compare, branches, no-ops, stalled store
      clear_mem();
      mem[0]  = instr(1, 50);   // load 123
      mem[1]  = instr(5, 51);   // cmp equal -> cc 1
      mem[2]  = instr(7, 10);   // taken
      mem[3]  = instr(0, 0);    // wrong path
      mem[10] = instr(5, 52);   // cmp 456 -> cc 0
      mem[11] = instr(7, 20);   // not taken
      mem[12] = instr(5, 51);   // cc 1
      mem[13] = instr(8, 60);   // no-op
      mem[14] = instr(9, 60);   // no-op
      mem[15] = instr(2, 60);   // store acc
      mem[16] = instr(7, 30);   // taken only if no-ops kept cc
      mem[17] = instr(0, 0);    // wrong path
      mem[20] = instr(0, 0);    // wrong path
      mem[30] = instr(6, 90);   // branch
      mem[90] = instr(0, 0);    // halt
      mem[50] = bcd3(123);
      mem[51] = bcd3(123);
      mem[52] = bcd3(456);
      run_prog(2, 1'b1);
      check("R8 R3 path ends after halt at 90", int'(pc), int'(8'h91));
      check("R7 acc kept by compares", val3(acc), 123);
      check("R11 cc kept across no-ops", int'(cc), 1);
      check("R4 R10 stalled store landed", val3(mem[60]), 123);
      check("R4 load source untouched", val3(mem[50]), 123);
      quiet_bad = 0;
      repeat (20) @(negedge clk);
      check("R9 halted sticky", int'(halted), 1);
      check("R9 no request after halt", quiet_bad, 0);
      check("R9 pc frozen after halt", int'(pc), int'(8'h91));

      // wrap program: execution passes address 99 into 00
      clear_mem();
      mem[0]  = instr(7, 20);   // first pass cc 0: not taken
      mem[1]  = instr(6, 99);
      mem[99] = instr(5, 71);   // 0 == 0 -> cc 1
      mem[20] = instr(0, 0);
      mem[71] = bcd3(0);
      run_prog(1, 1'b1);
      check("R2 pc wrapped 99 to 00 then branched", int'(pc), int'(8'h21));
      check("R7 compare equal sets cc", int'(cc), 1);
      check("R8 untaken branch kept acc", val3(acc), 0);

      // a no-op only program: sequential fetch
      clear_mem();
      mem[0] = instr(8, 5);
      mem[1] = instr(9, 7);
      mem[2] = instr(8, 0);
      mem[3] = instr(0, 0);
      run_prog(0, 1'b0);
      check("R2 R11 sequential through no-ops", int'(pc), int'(8'h04));
      check("R11 no-op leaves carry", int'(carry), 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule